// File: doc/BRIEF.md
# Predicated Vector Add Element Sequencer

This block carries out a single vector addition across a run of elements. The caller presents an element count, a 64-bit predicate mask, and two source register numbers and one destination register number. Each register has a vector/scalar flag and a 2-bit element-width code. The caller then raises `start`. The sequencer handles one element per clock. For each element it drives two indexed read requests and adds the two returned values. It presents the sum on a write port that carries a register number, an element index and an element-width code. The external register file packs or unpacks the element at the given width.

The predicate controls writing only. The element counter and the operand indices advance on every element whether or not its predicate bit is set, so each lane stays on the same element position. An operand marked scalar always uses element index 0. If the destination is scalar, the loop stops once the first write has been issued. A one-cycle `done` pulse marks the end of every operation, and this includes an operation with an element count of zero.

Top module: `vls_seq`

## Requirements
- R1: After reset, `busy`, `done` and `wr_en` are all low.
- R2: `start` is accepted only when `busy` is low. On acceptance the sequencer captures the element count, the predicate, the register numbers, the flags and the width codes. While `busy` is high, `start` and all operation inputs are ignored.
- R3: Element i (0-based) is processed in the i-th clock after the accepting edge. `wr_en` is high in that cycle exactly when predicate bit i is 1.
- R4: Width codes are 0 = 64 bits, 1 = 8 bits, 2 = 16 bits, 3 = 32 bits. Both reads use a single code, `rd1_wc` = `rd2_wc`, which selects the wider of the two source widths.
- R5: Each read value is truncated to the common source width before the add. The sum is truncated to the destination width, with all upper bits zero. It is written to the destination register using the destination width code.
- R6: A vector operand's index equals the current element number. A scalar operand's index is 0. Indices advance even for elements whose predicate bit is clear.
- R7: When the destination is scalar, the loop ends after the first element with `wr_en` high. If no such element occurs, the loop ends after all elements.
- R8: `done` is high for exactly one cycle, the cycle after the last processed element. `busy` is high from the accepting edge through the `done` cycle, and is low the cycle after.
- R9: An element count of 0 gives `done` in the first cycle after acceptance, with no writes.
- R10: An element count greater than MAXVL (64) is treated as MAXVL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (taken when idle) |
| vl | input | 7 | Element count |
| pred | input | 64 | Predicate mask, bit i gates element i |
| src1_reg | input | 7 | First source register number |
| src2_reg | input | 7 | Second source register number |
| dst_reg | input | 7 | Destination register number |
| src1_vec | input | 1 | First source is a vector |
| src2_vec | input | 1 | Second source is a vector |
| dst_vec | input | 1 | Destination is a vector |
| src1_wc | input | 2 | First source width code |
| src2_wc | input | 2 | Second source width code |
| dst_wc | input | 2 | Destination width code |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rd1_reg | output | 7 | Read port 1 register number |
| rd1_idx | output | 6 | Read port 1 element index |
| rd1_wc | output | 2 | Read port 1 width code |
| rd1_data | input | 64 | Read port 1 element value (same cycle) |
| rd2_reg | output | 7 | Read port 2 register number |
| rd2_idx | output | 6 | Read port 2 element index |
| rd2_wc | output | 2 | Read port 2 width code |
| rd2_data | input | 64 | Read port 2 element value (same cycle) |
| wr_en | output | 1 | Write strobe |
| wr_reg | output | 7 | Write register number |
| wr_idx | output | 6 | Write element index |
| wr_wc | output | 2 | Write width code |
| wr_data | output | 64 | Write value, truncated to destination width |

## Verification
A wrong element counter or operand index shows up at once. In the affected element's cycle, the read or write index is wrong and the written data does not match. A wrong predicate gate or a wrong width selection corrupts `wr_en` or `wr_data` in the same cycle as the element. A fault in termination, in the scalar early exit or in the count clamp moves `done` by one or more cycles. The bench detects this when it compares the cycle count at completion. A recapture of inputs while busy changes the register numbers and data on the next element.

// File: rtl/vls_pkg.sv
// Shared types and width helpers for the vector element sequencer.
// Assumes a 64-bit register element container and 2-bit width codes.
package vls_pkg;

    localparam int XLEN = 64;

    typedef enum logic [1:0] {
        WC_FULL = 2'd0,
        WC_B8   = 2'd1,
        WC_B16  = 2'd2,
        WC_B32  = 2'd3
    } wcode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } seq_st_e;

    typedef struct packed {
        logic   s1_vec;
        logic   s2_vec;
        logic   d_vec;
        wcode_e s1_wc;
        wcode_e s2_wc;
        wcode_e d_wc;
    } vflags_t;

    // Order of widths: larger rank means wider element.
    function automatic logic [1:0] wc_rank(input wcode_e wc);
        case (wc)
            WC_B8:   return 2'd0;
            WC_B16:  return 2'd1;
            WC_B32:  return 2'd2;
            default: return 2'd3;
        endcase
    endfunction

    // Bit mask that keeps the low bits of one element of the given width.
    function automatic logic [XLEN-1:0] wc_mask(input wcode_e wc);
        case (wc)
            WC_B8:   return XLEN'(64'h0000_0000_0000_00FF);
            WC_B16:  return XLEN'(64'h0000_0000_0000_FFFF);
            WC_B32:  return XLEN'(64'h0000_0000_FFFF_FFFF);
            default: return '1;
        endcase
    endfunction

endpackage

// File: rtl/vls_loop_ctrl.sv
// Element loop controller: accepts an operation, steps one element per
// clock, gates each element with its predicate bit and ends on the last
// element or after the first write when the destination is scalar.
// Assumes dst_vec is held stable by the parent while the loop runs.
module vls_loop_ctrl
    import vls_pkg::*;
#(
    parameter int MAXVL = 64,
    parameter int VL_W  = $clog2(MAXVL + 1),
    parameter int IDX_W = $clog2(MAXVL)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [VL_W-1:0]  vl_in,
    input  logic [MAXVL-1:0] pred_in,
    input  logic             dst_vec,
    output logic             accept,
    output logic             run,
    output logic             act,
    output logic             busy,
    output logic             done,
    output logic [IDX_W-1:0] elem
);

    seq_st_e          st;
    logic [VL_W-1:0]  vl_q;
    logic [MAXVL-1:0] pred_q;
    logic [VL_W-1:0]  vl_eff;
    logic             last;

    // Clamp the requested count to the supported maximum.
    always_comb begin
        vl_eff = (vl_in > VL_W'(MAXVL)) ? VL_W'(MAXVL) : vl_in;
    end

    // Decode state and the current element's gate and exit conditions.
    always_comb begin
        accept = (st == ST_IDLE) && start;
        run    = (st == ST_RUN);
        act    = run && pred_q[elem];
        last   = ((VL_W'(elem) + VL_W'(1)) == vl_q) || (act && !dst_vec);
        busy   = (st != ST_IDLE);
        done   = (st == ST_FIN);
    end

    // State, element counter and captured count/predicate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            elem   <= '0;
            vl_q   <= '0;
            pred_q <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        vl_q   <= vl_eff;
                        pred_q <= pred_in;
                        elem   <= '0;
                        st     <= (vl_eff == '0) ? ST_FIN : ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (last) begin
                        st <= ST_FIN;
                    end else begin
                        elem <= elem + IDX_W'(1);
                    end
                end
                ST_FIN:  st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/vls_lane_idx.sv
// Element index for one operand: follows the loop's element number when
// the operand is a vector, stays at zero when it is scalar.
// Assumes elem is the live element counter of the loop controller.
module vls_lane_idx #(
    parameter int IDX_W = 6
) (
    input  logic             run,
    input  logic             is_vec,
    input  logic [IDX_W-1:0] elem,
    output logic [IDX_W-1:0] idx
);

    // Select the lane position or the scalar slot.
    always_comb begin
        idx = (run && is_vec) ? elem : '0;
    end

endmodule

// File: rtl/vls_add_unit.sv
// Width-aware adder: picks the wider source width, truncates both read
// values to it, adds them and truncates the sum to the destination width.
// Assumes read values arrive in the same cycle as the request.
module vls_add_unit
    import vls_pkg::*;
(
    input  logic [XLEN-1:0] a_data,
    input  logic [XLEN-1:0] b_data,
    input  wcode_e          a_wc,
    input  wcode_e          b_wc,
    input  wcode_e          d_wc,
    output wcode_e          src_wc,
    output logic [XLEN-1:0] sum
);

    logic [XLEN-1:0] src_mask;

    // Choose the common source width from the two operand widths.
    always_comb begin
        src_wc   = (wc_rank(a_wc) >= wc_rank(b_wc)) ? a_wc : b_wc;
        src_mask = wc_mask(src_wc);
    end

    // Add truncated sources and trim the result to the destination width.
    always_comb begin
        sum = ((a_data & src_mask) + (b_data & src_mask)) & wc_mask(d_wc);
    end

endmodule

// File: rtl/vls_seq.sv
// Predicated vector add sequencer top: captures one operation, runs the
// element loop, drives two indexed read ports and one write port.
// Assumes a register file that answers reads combinationally and accepts
// a write in the cycle wr_en is high.
module vls_seq
    import vls_pkg::*;
#(
    parameter int MAXVL = 64,
    parameter int REG_W = 7,
    parameter int VL_W  = $clog2(MAXVL + 1),
    parameter int IDX_W = $clog2(MAXVL)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [VL_W-1:0]  vl,
    input  logic [MAXVL-1:0] pred,
    input  logic [REG_W-1:0] src1_reg,
    input  logic [REG_W-1:0] src2_reg,
    input  logic [REG_W-1:0] dst_reg,
    input  logic             src1_vec,
    input  logic             src2_vec,
    input  logic             dst_vec,
    input  logic [1:0]       src1_wc,
    input  logic [1:0]       src2_wc,
    input  logic [1:0]       dst_wc,
    output logic             busy,
    output logic             done,
    output logic [REG_W-1:0] rd1_reg,
    output logic [IDX_W-1:0] rd1_idx,
    output logic [1:0]       rd1_wc,
    input  logic [XLEN-1:0]  rd1_data,
    output logic [REG_W-1:0] rd2_reg,
    output logic [IDX_W-1:0] rd2_idx,
    output logic [1:0]       rd2_wc,
    input  logic [XLEN-1:0]  rd2_data,
    output logic             wr_en,
    output logic [REG_W-1:0] wr_reg,
    output logic [IDX_W-1:0] wr_idx,
    output logic [1:0]       wr_wc,
    output logic [XLEN-1:0]  wr_data
);

    localparam int NOPS = 3;

    logic             accept;
    logic             run;
    logic             act;
    logic [IDX_W-1:0] elem;
    vflags_t          flags;
    logic [REG_W-1:0] s1_reg_q;
    logic [REG_W-1:0] s2_reg_q;
    logic [REG_W-1:0] d_reg_q;
    logic             vec_a [NOPS];
    logic [IDX_W-1:0] idx_a [NOPS];
    wcode_e           src_wc;
    logic [XLEN-1:0]  sum;

    // Capture the operation's operands when the loop accepts it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags    <= '0;
            s1_reg_q <= '0;
            s2_reg_q <= '0;
            d_reg_q  <= '0;
        end else if (accept) begin
            flags.s1_vec <= src1_vec;
            flags.s2_vec <= src2_vec;
            flags.d_vec  <= dst_vec;
            flags.s1_wc  <= wcode_e'(src1_wc);
            flags.s2_wc  <= wcode_e'(src2_wc);
            flags.d_wc   <= wcode_e'(dst_wc);
            s1_reg_q     <= src1_reg;
            s2_reg_q     <= src2_reg;
            d_reg_q      <= dst_reg;
        end
    end

    vls_loop_ctrl #(
        .MAXVL (MAXVL),
        .VL_W  (VL_W),
        .IDX_W (IDX_W)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .vl_in   (vl),
        .pred_in (pred),
        .dst_vec (flags.d_vec),
        .accept  (accept),
        .run     (run),
        .act     (act),
        .busy    (busy),
        .done    (done),
        .elem    (elem)
    );

    // Gather the vector flags in operand order: source 1, source 2, dest.
    always_comb begin
        vec_a[0] = flags.s1_vec;
        vec_a[1] = flags.s2_vec;
        vec_a[2] = flags.d_vec;
    end

    for (genvar k = 0; k < NOPS; k++) begin : g_lane
        vls_lane_idx #(
            .IDX_W (IDX_W)
        ) u_idx (
            .run    (run),
            .is_vec (vec_a[k]),
            .elem   (elem),
            .idx    (idx_a[k])
        );
    end

    vls_add_unit u_add (
        .a_data (rd1_data),
        .b_data (rd2_data),
        .a_wc   (flags.s1_wc),
        .b_wc   (flags.s2_wc),
        .d_wc   (flags.d_wc),
        .src_wc (src_wc),
        .sum    (sum)
    );

    // Drive the read and write ports from captured operands and the loop.
    always_comb begin
        rd1_reg = s1_reg_q;
        rd1_idx = idx_a[0];
        rd1_wc  = src_wc;
        rd2_reg = s2_reg_q;
        rd2_idx = idx_a[1];
        rd2_wc  = src_wc;
        wr_en   = act;
        wr_reg  = d_reg_q;
        wr_idx  = idx_a[2];
        wr_wc   = flags.d_wc;
        wr_data = sum;
    end

endmodule

// File: rtl/vls_seq_chk.sv
// Property checker for the sequencer, bound to every vls_seq instance.
module vls_seq_chk
    import vls_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             done,
    input logic             run,
    input logic             wr_en,
    input logic [1:0]       wr_wc,
    input logic [XLEN-1:0]  wr_data,
    input logic [IDX_W-1:0] rd1_idx,
    input logic [IDX_W-1:0] rd2_idx,
    input logic [IDX_W-1:0] wr_idx,
    input logic [1:0]       rd1_wc,
    input logic [1:0]       rd2_wc,
    input vflags_t          flags
);

    // R3
    wr_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> busy);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R6
    scalar_src1_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !flags.s1_vec) |-> (rd1_idx == '0));

    // R6
    scalar_dst_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !flags.d_vec) |-> (wr_idx == '0));

    // R6
    vec_src2_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && flags.s2_vec) |-> (rd2_idx == $past(rd2_idx) + IDX_W'(1)));

    // R7
    scalar_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !flags.d_vec) |=> !run);

    // R4
    same_src_wc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (rd1_wc == rd2_wc));

    // R5
    narrow_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_wc == 2'd1) |-> (wr_data[XLEN-1:8] == '0));

endmodule

bind vls_seq vls_seq_chk #(
    .IDX_W (IDX_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .done    (done),
    .run     (run),
    .wr_en   (wr_en),
    .wr_wc   (wr_wc),
    .wr_data (wr_data),
    .rd1_idx (rd1_idx),
    .rd2_idx (rd2_idx),
    .wr_idx  (wr_idx),
    .rd1_wc  (rd1_wc),
    .rd2_wc  (rd2_wc),
    .flags   (flags)
);

// File: tb/tb_vls_seq.sv
module tb_vls_seq;

    localparam int CLK_PERIOD = 10;
    localparam int MAXVL = 64;
    localparam int REG_W = 7;
    localparam int VL_W  = 7;
    localparam int IDX_W = 6;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             start;
    logic [VL_W-1:0]  vl;
    logic [MAXVL-1:0] pred;
    logic [REG_W-1:0] src1_reg, src2_reg, dst_reg;
    logic             src1_vec, src2_vec, dst_vec;
    logic [1:0]       src1_wc, src2_wc, dst_wc;
    logic             busy, done;
    logic [REG_W-1:0] rd1_reg, rd2_reg, wr_reg;
    logic [IDX_W-1:0] rd1_idx, rd2_idx, wr_idx;
    logic [1:0]       rd1_wc, rd2_wc, wr_wc;
    logic [63:0]      rd1_data, rd2_data, wr_data;
    logic             wr_en;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Register file model: a distinct 64-bit pattern per register and index.
    function automatic logic [63:0] rf_val(input logic [REG_W-1:0] r, input logic [IDX_W-1:0] i);
        logic [63:0] x;
        x = {51'd0, r, i} + 64'd1;
        return (x * 64'h9E37_79B9_7F4A_7C15) ^ {i, 58'd0};
    endfunction

    function automatic int bw(input logic [1:0] wc);
        case (wc)
            2'd1:    return 8;
            2'd2:    return 16;
            2'd3:    return 32;
            default: return 64;
        endcase
    endfunction

    function automatic logic [63:0] msk(input logic [1:0] wc);
        return (bw(wc) == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << bw(wc)) - 64'd1);
    endfunction

    assign rd1_data = rf_val(rd1_reg, rd1_idx);
    assign rd2_data = rf_val(rd2_reg, rd2_idx);

    vls_seq #(.MAXVL(MAXVL), .REG_W(REG_W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .vl(vl), .pred(pred),
        .src1_reg(src1_reg), .src2_reg(src2_reg), .dst_reg(dst_reg),
        .src1_vec(src1_vec), .src2_vec(src2_vec), .dst_vec(dst_vec),
        .src1_wc(src1_wc), .src2_wc(src2_wc), .dst_wc(dst_wc),
        .busy(busy), .done(done),
        .rd1_reg(rd1_reg), .rd1_idx(rd1_idx), .rd1_wc(rd1_wc), .rd1_data(rd1_data),
        .rd2_reg(rd2_reg), .rd2_idx(rd2_idx), .rd2_wc(rd2_wc), .rd2_data(rd2_data),
        .wr_en(wr_en), .wr_reg(wr_reg), .wr_idx(wr_idx), .wr_wc(wr_wc), .wr_data(wr_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // One operation: drive, follow each element cycle, then check the ending.
    task automatic run_op(input logic [VL_W-1:0] v, input logic [63:0] p,
                          input logic [REG_W-1:0] a, input logic [REG_W-1:0] b, input logic [REG_W-1:0] d,
                          input bit va, input bit vb, input bit vd,
                          input logic [1:0] wa, input logic [1:0] wb, input logic [1:0] wd,
                          input bit bump);
        int vle, n, cyc;
        logic [1:0] sw;
        logic [IDX_W-1:0] i1, i2, id;
        logic [63:0] e;
        vle = (int'(v) > MAXVL) ? MAXVL : int'(v);
        n = vle;
        if (!vd) begin
            for (int k = 0; k < vle; k++) begin
                if (p[k]) begin n = k + 1; break; end
            end
        end
        sw = (bw(wa) >= bw(wb)) ? wa : wb;
        vl = v; pred = p; src1_reg = a; src2_reg = b; dst_reg = d;
        src1_vec = va; src2_vec = vb; dst_vec = vd;
        src1_wc = wa; src2_wc = wb; dst_wc = wd;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (done !== 1'b1 && cyc < MAXVL + 4) begin
            if (bump && cyc == 2) begin
                start = 1'b1; vl = 7'd1; src1_reg = a ^ 7'h15; dst_reg = d ^ 7'h2A;
                dst_vec = 1'b0; dst_wc = wd + 2'd1; pred = ~p;
            end
            if (bump && cyc == 3) start = 1'b0;
            if (cyc < n) begin
                i1 = va ? IDX_W'(cyc) : '0;
                i2 = vb ? IDX_W'(cyc) : '0;
                id = vd ? IDX_W'(cyc) : '0;
                chk(busy === 1'b1, "R8 busy during element", 64'(busy), 64'd1);
                chk(wr_en === p[cyc], "R3 predicate gate", 64'(wr_en), 64'(p[cyc]));
                chk(rd1_idx === i1 && rd2_idx === i2, "R6 source index",
                    {rd1_idx, rd2_idx}, {i1, i2});
                chk(rd1_wc === sw && rd2_wc === sw, "R4 common source width",
                    {rd1_wc, rd2_wc}, {sw, sw});
                chk(rd1_reg === a && rd2_reg === b, "R2 captured source regs",
                    {rd1_reg, rd2_reg}, {a, b});
                if (p[cyc]) begin
                    e = ((rf_val(a, i1) & msk(sw)) + (rf_val(b, i2) & msk(sw))) & msk(wd);
                    chk(wr_data === e, "R5 write data", wr_data, e);
                    chk(wr_wc === wd && wr_reg === d && wr_idx === id, "R6 R2 write target",
                        {wr_wc, wr_reg, wr_idx}, {wd, d, id});
                end
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        chk(cyc == n, "R7 R8 R9 R10 element count", 64'(cyc), 64'(n));
        chk(done === 1'b1 && wr_en === 1'b0, "R8 R9 done without write",
            {done, wr_en}, 2'b10);
        @(negedge clk);
        chk(done === 1'b0 && busy === 1'b0, "R8 done single pulse", {done, busy}, 2'b00);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++; tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; start = 1'b0; vl = '0; pred = '0;
        src1_reg = '0; src2_reg = '0; dst_reg = '0;
        src1_vec = 1'b0; src2_vec = 1'b0; dst_vec = 1'b0;
        src1_wc = '0; src2_wc = '0; dst_wc = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(busy === 1'b0 && done === 1'b0 && wr_en === 1'b0, "R1 reset outputs",
            {busy, done, wr_en}, 3'b000);

        // R9 zero count
        run_op(7'd0, '1, 7'd3, 7'd4, 7'd5, 1, 1, 1, 2'd0, 2'd0, 2'd0, 0);
        // R3 R6 all vector, full width, dense predicate
        run_op(7'd8, 64'hFF, 7'd1, 7'd2, 7'd9, 1, 1, 1, 2'd0, 2'd0, 2'd0, 0);
        // R6 indices still advance for masked elements
        run_op(7'd16, 64'hA5A5, 7'd10, 7'd11, 7'd12, 1, 0, 1, 2'd2, 2'd1, 2'd1, 0);
        // R7 scalar destination, first set bit at element 5
        run_op(7'd20, 64'h0000_0000_000F_FE20, 7'd20, 7'd21, 7'd22, 1, 1, 0, 2'd3, 2'd2, 2'd3, 0);
        // R7 scalar destination, no set bit: runs full count
        run_op(7'd9, 64'h0, 7'd30, 7'd31, 7'd32, 1, 1, 0, 2'd1, 2'd1, 2'd1, 0);
        // R4 wide source wins (8 vs 64), narrow destination
        run_op(7'd6, 64'h3F, 7'd40, 7'd41, 7'd42, 1, 1, 1, 2'd1, 2'd0, 2'd2, 0);
        // R10 count above maximum
        run_op(7'd100, '1, 7'd50, 7'd51, 7'd52, 1, 1, 1, 2'd3, 2'd3, 2'd3, 0);
        // R2 start and new inputs while busy are ignored
        run_op(7'd12, 64'h0F0F, 7'd60, 7'd61, 7'd62, 1, 1, 1, 2'd2, 2'd2, 2'd2, 1);

        // Constrained random operations
        for (int t = 0; t < 60; t++) begin
            logic [63:0] p;
            p = {$urandom, $urandom};
            if (t % 3 == 0) p = p & {$urandom, $urandom};
            run_op(VL_W'($urandom_range(0, 80)), p,
                   REG_W'($urandom), REG_W'($urandom), REG_W'($urandom),
                   1'($urandom), 1'($urandom), 1'($urandom),
                   2'($urandom), 2'($urandom), 2'($urandom), 0);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule